// File: doc/BRIEF.md
# Mesh Sieve Node

One node of a rectangular mesh that sieves a block of candidate positions one interval at a time. The interval holds `MESH_W * MESH_H * LOCS` positions, and each node owns `LOCS` consecutive positions. Each node holds a few arithmetic progressions. Each progression has a step, a next-hit phase and a weight. When an interval starts, the node walks its progressions and emits one packet (position, weight) for every hit that falls inside the interval. It keeps the phase that is left over for the next interval.

Packets travel through four neighbour links, first along the row and then along the column, until they reach the node that owns the position. That node consumes each packet and adds its weight to a saturating accumulator for the position. The node raises `quiet` when its generator has finished and none of its link buffers holds a packet. When every node is quiet, the environment raises `drain`. Each node then makes one pass over its own positions and reports every position whose accumulated score is at or above the threshold.

Top module: `msv_node`

## Requirements
- R1: On `iv_start` the generator visits the slots in ascending order. For an enabled slot with phase p and step s, it emits one packet for each position p, p+s, p+2s, ... below N = MESH_W*MESH_H*LOCS. The slot's phase then becomes the first position at or above N, minus N, and this value is used in the next interval.
- R2: Position a is owned by row (a/LOCS)/MESH_W and column (a/LOCS)%MESH_W. A packet whose owner column differs from the node's column leaves east (port index 1, column+1) or west (index 3, column-1). Otherwise a packet whose owner row differs leaves south (index 2, row+1) or north (index 0, row-1).
- R3: Each outgoing link has a one-entry buffer with valid/ready handshake. While valid is high and ready is low, the buffer holds its packet unchanged.
- R4: A packet owned by this node is consumed, and its weight is added to the accumulator at offset a % LOCS.
- R5: `iv_start` clears all accumulators and the candidate state, and restarts the generator from slot 0.
- R6: `quiet` is high exactly when the generator has finished and no outgoing buffer holds a packet. It is high after reset.
- R7: After `drain` is raised, the node visits its offsets 0..LOCS-1 in ascending order, one per cycle. For each offset whose score is >= `thr` it drives `cand_valid` with `cand_loc` = node base + offset and `cand_score` = the score. `cand_done` rises with the last offset and stays high until the next `iv_start`.
- R8: A slot loaded with step 0 is disabled. It emits no packets and its phase does not change.
- R9: An accumulator saturates at 2^ACW-1 and does not wrap.
- R10: A pulse on `ld_valid` while the generator is idle writes step, phase and weight into slot `ld_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 4 | Incoming packet valid per link (0 N, 1 E, 2 S, 3 W) |
| in_ready | output | 4 | Incoming packet accepted per link |
| in_addr | input | 4*AW | Incoming packet position per link |
| in_wt | input | 4*WW | Incoming packet weight per link |
| out_valid | output | 4 | Outgoing buffer valid per link |
| out_ready | input | 4 | Neighbour accepts outgoing packet |
| out_addr | output | 4*AW | Outgoing packet position per link |
| out_wt | output | 4*WW | Outgoing packet weight per link |
| ld_valid | input | 1 | Progression slot write strobe |
| ld_slot | input | SLW | Slot index to write |
| ld_step | input | SW | Progression step (0 disables the slot) |
| ld_phase | input | PHW | Next hit position relative to the interval start |
| ld_wt | input | WW | Weight added per hit |
| iv_start | input | 1 | Start of a new interval |
| drain | input | 1 | Mesh drained; start the threshold pass |
| thr | input | ACW | Candidate threshold |
| quiet | output | 1 | Generator finished and link buffers empty |
| cand_valid | output | 1 | A candidate position is reported this cycle |
| cand_loc | output | AW | Candidate position |
| cand_score | output | ACW | Candidate accumulated score |
| cand_done | output | 1 | Threshold pass complete |

## Verification
The routing assertions take for granted that every incoming packet carries a position below N and arrives on a link that lies on its row-then-column path. The bench keeps to this by connecting a 2x2 grid. In that grid, only packets made by the nodes' own generators ever enter a link, and the edge links are tied idle. The candidate assertion relies on `thr` being held steady through the pass. The bench changes the threshold only between intervals, and it raises `drain` only after every node reports `quiet`.

// File: rtl/msv_pkg.sv
package msv_pkg;

  typedef enum logic [2:0] {
    DIR_N   = 3'd0,
    DIR_E   = 3'd1,
    DIR_S   = 3'd2,
    DIR_W   = 3'd3,
    DIR_LOC = 3'd4
  } dir_e;

  function automatic int owner_row(int a, int locs, int mw);
    return (a / locs) / mw;
  endfunction

  function automatic int owner_col(int a, int locs, int mw);
    return (a / locs) % mw;
  endfunction

  function automatic int local_off(int a, int locs);
    return a % locs;
  endfunction

  // column first, then row
  function automatic dir_e route_dir(int a, int locs, int mw, int row, int col);
    int r;
    int c;
    r = owner_row(a, locs, mw);
    c = owner_col(a, locs, mw);
    if (c > col) return DIR_E;
    if (c < col) return DIR_W;
    if (r > row) return DIR_S;
    if (r < row) return DIR_N;
    return DIR_LOC;
  endfunction

endpackage

// File: rtl/msv_gen.sv
module msv_gen #(
  parameter int NPROG = 2,
  parameter int NTOT  = 16,
  parameter int AW    = 4,
  parameter int SW    = 5,
  parameter int PHW   = 6,
  parameter int WW    = 8,
  parameter int SLW   = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic [SLW-1:0] ld_slot,
  input  logic [SW-1:0]  ld_step,
  input  logic [PHW-1:0] ld_phase,
  input  logic [WW-1:0]  ld_wt,
  input  logic           iv_start,
  output logic           pkt_valid,
  input  logic           pkt_ready,
  output logic [AW-1:0]  pkt_addr,
  output logic [WW-1:0]  pkt_wt,
  output logic           busy
);

  logic [SW-1:0]  step_q  [NPROG];
  logic [PHW-1:0] phase_q [NPROG];
  logic [WW-1:0]  wt_q    [NPROG];
  logic [SLW-1:0] cur;
  logic           slot_on;
  logic           in_range;

  assign slot_on   = (step_q[cur] != '0);
  assign in_range  = (phase_q[cur] < PHW'(NTOT));
  assign pkt_valid = busy && slot_on && in_range;
  assign pkt_addr  = phase_q[cur][AW-1:0];
  assign pkt_wt    = wt_q[cur];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      for (int i = 0; i < NPROG; i++) begin
        step_q[i]  <= '0;
        phase_q[i] <= '0;
        wt_q[i]    <= '0;
      end
    end else if (iv_start) begin
      busy <= 1'b1;
      cur  <= '0;
    end else if (busy) begin
      if (pkt_valid) begin
        if (pkt_ready) phase_q[cur] <= phase_q[cur] + PHW'(step_q[cur]);
      end else begin
        if (slot_on) phase_q[cur] <= phase_q[cur] - PHW'(NTOT);
        if (cur == SLW'(NPROG - 1)) busy <= 1'b0;
        else cur <= cur + SLW'(1);
      end
    end else if (ld_valid) begin
      step_q[ld_slot]  <= ld_step;
      phase_q[ld_slot] <= ld_phase;
      wt_q[ld_slot]    <= ld_wt;
    end
  end

endmodule

// File: rtl/msv_xbar.sv
module msv_xbar
  import msv_pkg::*;
#(
  parameter int AW     = 4,
  parameter int WW     = 8,
  parameter int LOCS   = 4,
  parameter int MESH_W = 2,
  parameter int ROW    = 0,
  parameter int COL    = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          src_valid,
  input  logic [4:0][AW-1:0]  src_addr,
  input  logic [4:0][WW-1:0]  src_wt,
  output logic [4:0]          src_ready,
  output logic [3:0]          out_valid,
  input  logic [3:0]          out_ready,
  output logic [3:0][AW-1:0]  out_addr,
  output logic [3:0][WW-1:0]  out_wt,
  output logic                ej_valid,
  output logic [AW-1:0]       ej_addr,
  output logic [WW-1:0]       ej_wt
);

  localparam int NSRC = 5;
  localparam int NDST = 5;

  dir_e       sdir  [NSRC];
  logic       gnt_v [NDST];
  logic [2:0] gnt_s [NDST];
  logic       take  [NDST];
  logic [2:0] rot;

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      sdir[s] = route_dir(int'(src_addr[s]), LOCS, MESH_W, ROW, COL);
    for (int o = 0; o < NDST; o++) begin
      gnt_v[o] = 1'b0;
      gnt_s[o] = '0;
      for (int k = 0; k < NSRC; k++) begin
        int s;
        s = (int'(rot) + k) % NSRC;
        if (!gnt_v[o] && src_valid[s] && sdir[s] == dir_e'(o)) begin
          gnt_v[o] = 1'b1;
          gnt_s[o] = 3'(s);
        end
      end
      take[o] = (o < 4) ? !out_valid[o % 4] : 1'b1;
    end
    for (int s = 0; s < NSRC; s++) begin
      src_ready[s] = 1'b0;
      for (int o = 0; o < NDST; o++)
        if (gnt_v[o] && take[o] && gnt_s[o] == 3'(s)) src_ready[s] = 1'b1;
    end
  end

  assign ej_valid = gnt_v[4];
  assign ej_addr  = src_addr[gnt_s[4]];
  assign ej_wt    = src_wt[gnt_s[4]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rot <= '0;
    else        rot <= (rot == 3'd4) ? 3'd0 : rot + 3'd1;
  end

  for (genvar o = 0; o < 4; o++) begin : g_obuf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid[o] <= 1'b0;
        out_addr[o]  <= '0;
        out_wt[o]    <= '0;
      end else if (gnt_v[o] && take[o]) begin
        out_valid[o] <= 1'b1;
        out_addr[o]  <= src_addr[gnt_s[o]];
        out_wt[o]    <= src_wt[gnt_s[o]];
      end else if (out_ready[o]) begin
        out_valid[o] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/msv_acc.sv
module msv_acc
  import msv_pkg::*;
#(
  parameter int LOCS = 4,
  parameter int BASE = 0,
  parameter int AW   = 4,
  parameter int WW   = 8,
  parameter int ACW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           ej_valid,
  input  logic [AW-1:0]  ej_addr,
  input  logic [WW-1:0]  ej_wt,
  input  logic           drain,
  input  logic [ACW-1:0] thr,
  output logic           cand_valid,
  output logic [AW-1:0]  cand_loc,
  output logic [ACW-1:0] cand_score,
  output logic           cand_done
);

  localparam int LW = (LOCS > 1) ? $clog2(LOCS) : 1;

  logic [ACW-1:0] acc [LOCS];
  logic [LW-1:0]  off;
  logic [ACW:0]   sum;
  logic [ACW-1:0] sat_val;
  logic           started;
  logic           scanning;
  logic [LW-1:0]  sidx;

  assign off     = LW'(local_off(int'(ej_addr), LOCS));
  assign sum     = {1'b0, acc[off]} + (ACW + 1)'(ej_wt);
  assign sat_val = sum[ACW] ? {ACW{1'b1}} : sum[ACW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOCS; i++) acc[i] <= '0;
      started    <= 1'b0;
      scanning   <= 1'b0;
      sidx       <= '0;
      cand_valid <= 1'b0;
      cand_loc   <= '0;
      cand_score <= '0;
      cand_done  <= 1'b0;
    end else if (clear) begin
      for (int i = 0; i < LOCS; i++) acc[i] <= '0;
      started    <= 1'b0;
      scanning   <= 1'b0;
      sidx       <= '0;
      cand_valid <= 1'b0;
      cand_done  <= 1'b0;
    end else begin
      if (ej_valid) acc[off] <= sat_val;
      if (drain && !started) begin
        started  <= 1'b1;
        scanning <= 1'b1;
        sidx     <= '0;
      end
      if (scanning) begin
        cand_valid <= (acc[sidx] >= thr);
        cand_loc   <= AW'(BASE) + AW'(sidx);
        cand_score <= acc[sidx];
        sidx       <= sidx + LW'(1);
        if (sidx == LW'(LOCS - 1)) begin
          scanning  <= 1'b0;
          cand_done <= 1'b1;
        end
      end else begin
        cand_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/msv_node.sv
module msv_node
  import msv_pkg::*;
#(
  parameter int MESH_W = 2,
  parameter int MESH_H = 2,
  parameter int ROW    = 0,
  parameter int COL    = 0,
  parameter int LOCS   = 4,
  parameter int NPROG  = 2,
  parameter int SW     = 5,
  parameter int WW     = 8,
  parameter int ACW    = 8,
  localparam int NTOT  = MESH_W * MESH_H * LOCS,
  localparam int AW    = (NTOT > 1) ? $clog2(NTOT) : 1,
  localparam int PHW   = ((AW > SW) ? AW : SW) + 1,
  localparam int SLW   = (NPROG > 1) ? $clog2(NPROG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         in_valid,
  output logic [3:0]         in_ready,
  input  logic [3:0][AW-1:0] in_addr,
  input  logic [3:0][WW-1:0] in_wt,
  output logic [3:0]         out_valid,
  input  logic [3:0]         out_ready,
  output logic [3:0][AW-1:0] out_addr,
  output logic [3:0][WW-1:0] out_wt,
  input  logic               ld_valid,
  input  logic [SLW-1:0]     ld_slot,
  input  logic [SW-1:0]      ld_step,
  input  logic [PHW-1:0]     ld_phase,
  input  logic [WW-1:0]      ld_wt,
  input  logic               iv_start,
  input  logic               drain,
  input  logic [ACW-1:0]     thr,
  output logic               quiet,
  output logic               cand_valid,
  output logic [AW-1:0]      cand_loc,
  output logic [ACW-1:0]     cand_score,
  output logic               cand_done
);

  localparam int BASE = (ROW * MESH_W + COL) * LOCS;

  // named internal events, visible to the checker
  logic              gen_valid;
  logic              gen_ready;
  logic [AW-1:0]     gen_addr;
  logic [WW-1:0]     gen_wt;
  logic              gen_busy;
  logic              ej_valid;
  logic [AW-1:0]     ej_addr;
  logic [WW-1:0]     ej_wt;
  logic [4:0]        src_valid;
  logic [4:0]        src_ready;
  logic [4:0][AW-1:0] src_addr;
  logic [4:0][WW-1:0] src_wt;

  always_comb begin
    for (int d = 0; d < 4; d++) begin
      src_valid[d] = in_valid[d];
      src_addr[d]  = in_addr[d];
      src_wt[d]    = in_wt[d];
    end
    src_valid[4] = gen_valid;
    src_addr[4]  = gen_addr;
    src_wt[4]    = gen_wt;
  end

  assign in_ready  = src_ready[3:0];
  assign gen_ready = src_ready[4];
  assign quiet     = !gen_busy && (out_valid == 4'b0000);

  msv_gen #(
    .NPROG(NPROG), .NTOT(NTOT), .AW(AW), .SW(SW), .PHW(PHW), .WW(WW), .SLW(SLW)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_step(ld_step),
    .ld_phase(ld_phase), .ld_wt(ld_wt),
    .iv_start(iv_start),
    .pkt_valid(gen_valid), .pkt_ready(gen_ready),
    .pkt_addr(gen_addr), .pkt_wt(gen_wt),
    .busy(gen_busy)
  );

  msv_xbar #(
    .AW(AW), .WW(WW), .LOCS(LOCS), .MESH_W(MESH_W), .ROW(ROW), .COL(COL)
  ) u_xbar (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_addr(src_addr), .src_wt(src_wt),
    .src_ready(src_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wt(out_wt),
    .ej_valid(ej_valid), .ej_addr(ej_addr), .ej_wt(ej_wt)
  );

  msv_acc #(
    .LOCS(LOCS), .BASE(BASE), .AW(AW), .WW(WW), .ACW(ACW)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(iv_start),
    .ej_valid(ej_valid), .ej_addr(ej_addr), .ej_wt(ej_wt),
    .drain(drain), .thr(thr),
    .cand_valid(cand_valid), .cand_loc(cand_loc),
    .cand_score(cand_score), .cand_done(cand_done)
  );

endmodule

// File: rtl/msv_node_chk.sv
module msv_node_chk
  import msv_pkg::*;
#(
  parameter int MESH_W = 2,
  parameter int ROW    = 0,
  parameter int COL    = 0,
  parameter int LOCS   = 4,
  parameter int AW     = 4,
  parameter int WW     = 8,
  parameter int ACW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         out_valid,
  input logic [3:0]         out_ready,
  input logic [3:0][AW-1:0] out_addr,
  input logic [3:0][WW-1:0] out_wt,
  input logic               gen_valid,
  input logic               gen_ready,
  input logic [AW-1:0]      gen_addr,
  input logic               ej_valid,
  input logic [AW-1:0]      ej_addr,
  input logic               cand_valid,
  input logic [AW-1:0]      cand_loc,
  input logic [ACW-1:0]     cand_score,
  input logic [ACW-1:0]     thr,
  input logic               quiet
);

  // R1: a generated packet waits unchanged until the router takes it
  assert_gen_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid && !gen_ready |=> gen_valid && $stable(gen_addr));

  // R2: each buffered packet sits on a port of its row-then-column path
  assert_route_east_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> owner_col(int'(out_addr[1]), LOCS, MESH_W) > COL);
  assert_route_west_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[3] |-> owner_col(int'(out_addr[3]), LOCS, MESH_W) < COL);
  assert_route_north_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> owner_col(int'(out_addr[0]), LOCS, MESH_W) == COL
                  && owner_row(int'(out_addr[0]), LOCS, MESH_W) < ROW);
  assert_route_south_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] |-> owner_col(int'(out_addr[2]), LOCS, MESH_W) == COL
                  && owner_row(int'(out_addr[2]), LOCS, MESH_W) > ROW);

  // R3: a stalled link holds its packet
  for (genvar d = 0; d < 4; d++) begin : g_hold
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[d] && !out_ready[d] |=>
        out_valid[d] && $stable(out_addr[d]) && $stable(out_wt[d]));
  end

  // R4: only packets owned here are consumed
  assert_eject_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> owner_row(int'(ej_addr), LOCS, MESH_W) == ROW
              && owner_col(int'(ej_addr), LOCS, MESH_W) == COL);

  // R6: a quiet node has no packet pending in its generator
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !gen_valid);

  // R7: reported candidates are local and pass the threshold
  assert_cand_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> cand_score >= thr
                && owner_row(int'(cand_loc), LOCS, MESH_W) == ROW
                && owner_col(int'(cand_loc), LOCS, MESH_W) == COL);

endmodule

bind msv_node msv_node_chk #(
  .MESH_W(MESH_W), .ROW(ROW), .COL(COL), .LOCS(LOCS),
  .AW(AW), .WW(WW), .ACW(ACW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_wt(out_wt),
  .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_addr(gen_addr),
  .ej_valid(ej_valid), .ej_addr(ej_addr),
  .cand_valid(cand_valid), .cand_loc(cand_loc),
  .cand_score(cand_score), .thr(thr), .quiet(quiet)
);

// File: tb/tb_msv_node.sv
module tb_msv_node;

  localparam int W = 2, H = 2, L = 4, NP = 2;
  localparam int NN = W * H, N = NN * L;
  localparam int AW = 4, SW = 5, PHW = 6, WW = 8, ACW = 8;
  localparam int SATMAX = 255;
  localparam int NV = 3, NS = NN * NP;
  localparam int LIMIT = 150000;

  // stimulus table: slot order is node0 s0, node0 s1, node1 s0, ...
  localparam int TV_STEP  [NV][NS] = '{
    '{3, 5, 2, 0, 7, 4, 20, 1},
    '{1, 1, 0, 0, 0, 0, 0, 3},
    '{6, 0, 0, 9, 11, 0, 0, 13}};
  localparam int TV_PHASE [NV][NS] = '{
    '{0, 1, 1, 0, 2, 3, 3, 15},
    '{0, 0, 0, 0, 0, 0, 0, 2},
    '{5, 0, 0, 30, 4, 0, 0, 0}};
  localparam int TV_WT    [NV][NS] = '{
    '{4, 3, 2, 9, 6, 5, 8, 1},
    '{200, 100, 0, 0, 0, 0, 0, 60},
    '{7, 0, 0, 5, 9, 0, 0, 11}};
  localparam int TV_THR   [NV] = '{9, 250, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]         iv [NN], ir [NN], ov [NN], orr [NN];
  logic [3:0][AW-1:0] ia [NN], oa [NN];
  logic [3:0][WW-1:0] iw [NN], ow [NN];
  logic [NN-1:0]      ld_v;
  logic [0:0]         ld_slot;
  logic [SW-1:0]      ld_step;
  logic [PHW-1:0]     ld_phase;
  logic [WW-1:0]      ld_wt;
  logic               iv_start, drain;
  logic [ACW-1:0]     thr;
  logic               quiet [NN], cv [NN], cd [NN];
  logic [AW-1:0]      cl [NN];
  logic [ACW-1:0]     cs [NN];

  function automatic int nbr(int n, int d);
    int r, c;
    r = n / W;
    c = n % W;
    case (d)
      0: return (r > 0) ? n - W : -1;
      1: return (c < W - 1) ? n + 1 : -1;
      2: return (r < H - 1) ? n + W : -1;
      default: return (c > 0) ? n - 1 : -1;
    endcase
  endfunction

  always_comb begin
    for (int n = 0; n < NN; n++) begin
      for (int d = 0; d < 4; d++) begin
        int m;
        m = nbr(n, d);
        if (m >= 0) begin
          iv[n][d]  = ov[m][(d + 2) % 4];
          ia[n][d]  = oa[m][(d + 2) % 4];
          iw[n][d]  = ow[m][(d + 2) % 4];
          orr[n][d] = ir[m][(d + 2) % 4];
        end else begin
          iv[n][d]  = 1'b0;
          ia[n][d]  = '0;
          iw[n][d]  = '0;
          orr[n][d] = 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < H; r++) begin : g_r
    for (genvar c = 0; c < W; c++) begin : g_c
      localparam int ID = r * W + c;
      msv_node #(.MESH_W(W), .MESH_H(H), .ROW(r), .COL(c), .LOCS(L),
                 .NPROG(NP), .SW(SW), .WW(WW), .ACW(ACW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(iv[ID]), .in_ready(ir[ID]), .in_addr(ia[ID]), .in_wt(iw[ID]),
        .out_valid(ov[ID]), .out_ready(orr[ID]), .out_addr(oa[ID]), .out_wt(ow[ID]),
        .ld_valid(ld_v[ID]), .ld_slot(ld_slot), .ld_step(ld_step),
        .ld_phase(ld_phase), .ld_wt(ld_wt),
        .iv_start(iv_start), .drain(drain), .thr(thr),
        .quiet(quiet[ID]), .cand_valid(cv[ID]), .cand_loc(cl[ID]),
        .cand_score(cs[ID]), .cand_done(cd[ID]));
    end
  end

  int tests = 0, fails = 0, cyc = 0;
  bit timed_out = 1'b0;
  bit clr_col = 1'b0;
  int hit_cnt [N];
  int hit_sc  [N];
  int model_ph [NS];
  int expv [N];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (clr_col) begin
      for (int a = 0; a < N; a++) begin
        hit_cnt[a] = 0;
        hit_sc[a] = 0;
      end
    end else begin
      for (int n = 0; n < NN; n++)
        if (cv[n]) begin
          hit_cnt[int'(cl[n])] = hit_cnt[int'(cl[n])] + 1;
          hit_sc[int'(cl[n])] = int'(cs[n]);
        end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit all_quiet();
    for (int n = 0; n < NN; n++) if (!quiet[n]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit all_done();
    for (int n = 0; n < NN; n++) if (!cd[n]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic load_slot(input int n, input int k, input int st, input int ph, input int w);
    @(negedge clk);
    ld_v = '0;
    ld_v[n] = 1'b1;
    ld_slot = 1'(k);
    ld_step = SW'(st);
    ld_phase = PHW'(ph);
    ld_wt = WW'(w);
    @(negedge clk);
    ld_v = '0;
    model_ph[n * NP + k] = ph;
  endtask

  // reference model of one interval: expected scores and carried phases
  task automatic model_interval(input int v, input bit zero_all);
    for (int a = 0; a < N; a++) expv[a] = 0;
    if (!zero_all) begin
      for (int s = 0; s < NS; s++) begin
        if (TV_STEP[v][s] != 0) begin
          int a;
          a = model_ph[s];
          while (a < N) begin
            expv[a] = (expv[a] + TV_WT[v][s] > SATMAX) ? SATMAX : expv[a] + TV_WT[v][s];
            a = a + TV_STEP[v][s];
          end
          model_ph[s] = a - N;
        end
      end
    end
  endtask

  task automatic run_interval(input int th);
    @(negedge clk);
    thr = ACW'(th);
    clr_col = 1'b1;
    iv_start = 1'b1;
    @(negedge clk);
    clr_col = 1'b0;
    iv_start = 1'b0;
    repeat (2) @(negedge clk);
    while (!all_quiet() && !timed_out) begin
      @(negedge clk);
      if (cyc > LIMIT) timed_out = 1'b1;
    end
    drain = 1'b1;
    @(negedge clk);
    while (!all_done() && !timed_out) begin
      @(negedge clk);
      if (cyc > LIMIT) timed_out = 1'b1;
    end
    repeat (2) @(negedge clk);
    drain = 1'b0;
  endtask

  task automatic check_locs(input int th, input string tag);
    for (int a = 0; a < N; a++) begin
      if (expv[a] >= th) begin
        chk(hit_cnt[a] == 1, {tag, " R7 count"}, hit_cnt[a], 1);
        chk(hit_sc[a] == expv[a], {tag, " R2 R3 R4 R9 score"}, hit_sc[a], expv[a]);
      end else begin
        chk(hit_cnt[a] == 0, {tag, " R7 below threshold"}, hit_cnt[a], 0);
      end
    end
    chk(all_quiet(), {tag, " R6 quiet after pass"}, int'(all_quiet()), 1);
  endtask

  initial begin
    ld_v = '0;
    ld_slot = '0;
    ld_step = '0;
    ld_phase = '0;
    ld_wt = '0;
    iv_start = 1'b0;
    drain = 1'b0;
    thr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    for (int n = 0; n < NN; n++) begin
      chk(quiet[n] == 1'b1, "R6 quiet after reset", int'(quiet[n]), 1);
      chk(ov[n] == 4'b0000, "R3 buffers empty after reset", int'(ov[n]), 0);
      chk(cd[n] == 1'b0 && cv[n] == 1'b0, "R7 no candidate after reset",
          int'(cd[n]) + int'(cv[n]), 0);
    end

    // table walk: each vector loaded once, then two intervals (phase carry R1)
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < NS; s++)
        load_slot(s / NP, s % NP, TV_STEP[v][s], TV_PHASE[v][s], TV_WT[v][s]);
      for (int it = 0; it < 2; it++) begin
        model_interval(v, 1'b0);
        run_interval(TV_THR[v]);
        check_locs(TV_THR[v], (it == 0) ? "R1 R8 R10 first" : "R1 R5 carried");
      end
    end

    // directed: all slots disabled, threshold 1 -> accumulators were cleared (R5)
    for (int s = 0; s < NS; s++) load_slot(s / NP, s % NP, 0, 0, 50);
    model_interval(0, 1'b1);
    run_interval(1);
    check_locs(1, "R5 R8 cleared");

    // directed: threshold 0 with nothing emitted -> every location reported with score 0
    run_interval(0);
    check_locs(0, "R7 threshold zero");

    if (timed_out) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(LIMIT * 10 + 20000);
    $display("FAIL watchdog hard stop actual=%0d expected=%0d", cyc, LIMIT);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

endmodule